// File: doc/BRIEF.md
# Shared Bidirectional Pin Port with Serial and Display-Timing Takeover

This block is a twelve-pin general-purpose port split into three four-pin groups. Every group holds three small registers on a 4-bit register bus: a direction register, a pull-up register and a data register. For each pin the block drives an output value, an output enable and a pull-up enable, and it reads back the pin level. Software uses the port directly as plain digital inputs and outputs.

Two groups can also be lent to other blocks. The middle group can be handed to a clock-synchronous serial shift engine, which sits outside this block. The engine can run as clock master or as clock slave, and the port routes its data, clock and ready lines onto the pins. The two upper pins of the last group can carry a display clock and a display frame signal. When a pin is taken over, its registers stay readable and writable. Depending on the mode, those registers either become plain storage or control the pull-up of a pin the serial engine uses as an input.

Top module: `gpio_port`

## Requirements
- R1: After reset, every direction register reads 0, every pull-up register reads 4'hF and the mode register reads 0. All output enables are low and all pull-ups are on. The serial input and serial clock input return to the engine idle at 1.
- R2: Register addresses are group*4 + kind, where kind 0 is data, 1 is direction and 2 is pull-up. A written direction bit of 1 enables that pin's output in the next cycle, and the pin drives its data bit.
- R3: A pull-up is on only when its pin is not driven and its pull-up bit is 1. No pin ever has its output enable and its pull-up on together.
- R4: Reading a data register returns the pad level for pins in input mode and the latched bit for pins in output mode.
- R5: The mode register is at address 12, with bit0 serial enable, bit1 slave select, bit2 display clock enable and bit3 display frame enable. With serial enabled, pin 4 is an undriven serial input that is passed to the engine, and its pull-up follows pull-up bit 4. Pin 5 drives the engine's serial output. With serial disabled, pins 4 to 7 follow their own registers.
- R6: In master mode, pin 6 drives the engine's clock output, and pull-up bit 6 is plain storage with no pull-up effect.
- R7: In slave mode, pin 6 is an undriven clock input that is passed to the engine, and its pull-up follows pull-up bit 6. Pin 7 drives the engine's ready output, and its direction, pull-up and data bits become plain storage.
- R8: In master mode, pin 7 keeps working as a general-purpose pin under its own registers.
- R9: Display clock enable makes pin 10 drive the display clock, and display frame enable makes pin 11 drive the display frame, each with its pull-up off. Clearing an enable returns that pin to its registers.
- R10: For any taken-over pin, a data register read returns the latched register bit, not the pad level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wrData | input | 4 | Write data |
| rdData | output | 4 | Combinational read data at addr |
| padIn | input | 12 | Pin levels |
| padOut | output | 12 | Pin output values |
| padOe | output | 12 | Pin output enables |
| padPu | output | 12 | Pin pull-up enables |
| serOut | input | 1 | Serial data from the shift engine |
| serClkOut | input | 1 | Serial clock from the engine (master) |
| serRdyOut | input | 1 | Ready signal from the engine (slave) |
| serIn | output | 1 | Serial data to the engine |
| serClkIn | output | 1 | Serial clock to the engine (slave) |
| lcdClk | input | 1 | Display clock |
| lcdFrame | input | 1 | Display frame signal |

## Verification
A wrong mode register or a wrong takeover mask shows up at the pins right away. In the first cycle after the mode write, a pin drives when it should float, floats when it should drive, or shows a pull-up that the mode rules out. A register that drifts while it serves as storage stays hidden at the pins. It shows only when it is read back, or when serial mode is turned off and the pin falls back to its registers, so the scenarios read every storage register and then leave serial mode. A read mux that picks the pad level instead of the latch shows up only when the pad differs from the register bit, so the pad levels are set against the stored values before each read.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int GRP_W = 4;
  localparam int GRP_N = 3;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] MODE_ADDR = 4'hC;

  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_DIR  = 2'd1,
    KIND_PULL = 2'd2,
    KIND_NONE = 2'd3
  } regKindE;

  typedef struct packed {
    logic [GRP_N-1:0] grpSel;
    logic             wrDat;
    logic             wrDir;
    logic             wrPull;
    logic [GRP_W-1:0] val;
  } wrStrobeT;

  typedef struct packed {
    logic serEn;
    logic serSlave;
    logic lcdClkEn;
    logic lcdFrmEn;
  } modeT;
endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [GRP_W-1:0]  wrData,
  output wrStrobeT          strb,
  output modeT              mode
);
  regKindE kind;
  logic [1:0] grpIdx;

  assign kind   = regKindE'(addr[1:0]);
  assign grpIdx = addr[3:2];

  // decode a bus write into one group strobe plus one register kind
  always_comb begin
    strb = '0;
    strb.val = wrData;
    if (wrEn) begin
      for (int g = 0; g < GRP_N; g++) begin
        if (grpIdx == 2'(g)) strb.grpSel[g] = 1'b1;
      end
      unique case (kind)
        KIND_DATA: strb.wrDat  = 1'b1;
        KIND_DIR:  strb.wrDir  = 1'b1;
        KIND_PULL: strb.wrPull = 1'b1;
        default:   ;
      endcase
    end
  end

  // takeover mode register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode <= '0;
    end else if (wrEn && addr == MODE_ADDR) begin
      mode.serEn    <= wrData[0];
      mode.serSlave <= wrData[1];
      mode.lcdClkEn <= wrData[2];
      mode.lcdFrmEn <= wrData[3];
    end
  end
endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int SER_GRP = 1,
  parameter int LCD_GRP = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  wrStrobeT               strb,
  input  modeT                   mode,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [GRP_N*GRP_W-1:0] padIn,
  input  logic                   serOut,
  input  logic                   serClkOut,
  input  logic                   serRdyOut,
  input  logic                   lcdClk,
  input  logic                   lcdFrame,
  output logic [GRP_N*GRP_W-1:0] padOut,
  output logic [GRP_N*GRP_W-1:0] padOe,
  output logic [GRP_N*GRP_W-1:0] padPu,
  output logic                   serIn,
  output logic                   serClkIn,
  output logic [GRP_W-1:0]       rdData
);
  localparam int PIN_N = GRP_N * GRP_W;
  localparam int PIN_SIN = SER_GRP * GRP_W;
  localparam int PIN_SOUT = PIN_SIN + 1;
  localparam int PIN_SCK = PIN_SIN + 2;
  localparam int PIN_RDY = PIN_SIN + 3;
  localparam int PIN_LCK = LCD_GRP * GRP_W + 2;
  localparam int PIN_LFR = LCD_GRP * GRP_W + 3;

  logic [PIN_N-1:0] datFlat, dirFlat, pullFlat;
  logic [PIN_N-1:0] outV, oeV, puV, taken, latchSel, readPins;

  // per-group register triplets
  for (genvar g = 0; g < GRP_N; g++) begin : gen_grp
    logic [GRP_W-1:0] datReg, dirReg, pullReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        datReg  <= '0;
        dirReg  <= '0;
        pullReg <= '1;
      end else if (strb.grpSel[g]) begin
        if (strb.wrDat)  datReg  <= strb.val;
        if (strb.wrDir)  dirReg  <= strb.val;
        if (strb.wrPull) pullReg <= strb.val;
      end
    end
    assign datFlat[g*GRP_W +: GRP_W]  = datReg;
    assign dirFlat[g*GRP_W +: GRP_W]  = dirReg;
    assign pullFlat[g*GRP_W +: GRP_W] = pullReg;
  end

  // pin steering: general-purpose default, then takeover overrides
  always_comb begin
    outV  = datFlat;
    oeV   = dirFlat;
    puV   = pullFlat & ~dirFlat;
    taken = '0;
    if (mode.serEn) begin
      taken[PIN_SIN]  = 1'b1;
      oeV[PIN_SIN]    = 1'b0;
      puV[PIN_SIN]    = pullFlat[PIN_SIN];
      taken[PIN_SOUT] = 1'b1;
      oeV[PIN_SOUT]   = 1'b1;
      outV[PIN_SOUT]  = serOut;
      puV[PIN_SOUT]   = 1'b0;
      taken[PIN_SCK]  = 1'b1;
      if (mode.serSlave) begin
        oeV[PIN_SCK]   = 1'b0;
        puV[PIN_SCK]   = pullFlat[PIN_SCK];
        taken[PIN_RDY] = 1'b1;
        oeV[PIN_RDY]   = 1'b1;
        outV[PIN_RDY]  = serRdyOut;
        puV[PIN_RDY]   = 1'b0;
      end else begin
        oeV[PIN_SCK]  = 1'b1;
        outV[PIN_SCK] = serClkOut;
        puV[PIN_SCK]  = 1'b0;
      end
    end
    if (mode.lcdClkEn) begin
      taken[PIN_LCK] = 1'b1;
      oeV[PIN_LCK]   = 1'b1;
      outV[PIN_LCK]  = lcdClk;
      puV[PIN_LCK]   = 1'b0;
    end
    if (mode.lcdFrmEn) begin
      taken[PIN_LFR] = 1'b1;
      oeV[PIN_LFR]   = 1'b1;
      outV[PIN_LFR]  = lcdFrame;
      puV[PIN_LFR]   = 1'b0;
    end
  end

  assign padOut = outV;
  assign padOe  = oeV;
  assign padPu  = puV;

  assign serIn    = mode.serEn ? padIn[PIN_SIN] : 1'b1;
  assign serClkIn = (mode.serEn && mode.serSlave) ? padIn[PIN_SCK] : 1'b1;

  // data readback: latch for driven or taken pins, pad level otherwise
  assign latchSel = taken | dirFlat;
  assign readPins = (datFlat & latchSel) | (padIn & ~latchSel);

  always_comb begin
    rdData = '0;
    if (addr == MODE_ADDR) begin
      rdData = {mode.lcdFrmEn, mode.lcdClkEn, mode.serSlave, mode.serEn};
    end else begin
      for (int g = 0; g < GRP_N; g++) begin
        if (addr[3:2] == 2'(g)) begin
          unique case (regKindE'(addr[1:0]))
            KIND_DATA: rdData = readPins[g*GRP_W +: GRP_W];
            KIND_DIR:  rdData = dirFlat[g*GRP_W +: GRP_W];
            KIND_PULL: rdData = pullFlat[g*GRP_W +: GRP_W];
            default:   rdData = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  addr,
  input  logic [3:0]  wrData,
  output logic [3:0]  rdData,
  input  logic [11:0] padIn,
  output logic [11:0] padOut,
  output logic [11:0] padOe,
  output logic [11:0] padPu,
  input  logic        serOut,
  input  logic        serClkOut,
  input  logic        serRdyOut,
  output logic        serIn,
  output logic        serClkIn,
  input  logic        lcdClk,
  input  logic        lcdFrame
);
  wrStrobeT strb;
  modeT     mode;

  gpio_port_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .strb   (strb),
    .mode   (mode)
  );

  gpio_port_datapath #(.SER_GRP(1), .LCD_GRP(2)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .mode      (mode),
    .addr      (addr),
    .padIn     (padIn),
    .serOut    (serOut),
    .serClkOut (serClkOut),
    .serRdyOut (serRdyOut),
    .lcdClk    (lcdClk),
    .lcdFrame  (lcdFrame),
    .padOut    (padOut),
    .padOe     (padOe),
    .padPu     (padPu),
    .serIn     (serIn),
    .serClkIn  (serClkIn),
    .rdData    (rdData)
  );
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker
  import gpio_port_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [3:0]  addr,
  input logic [3:0]  wrData,
  input logic [11:0] padIn,
  input logic [11:0] padOut,
  input logic [11:0] padOe,
  input logic [11:0] padPu,
  input logic        serOut,
  input logic        serClkOut,
  input logic        serIn,
  input logic        serClkIn,
  input logic        lcdClk,
  input modeT        mode
);
  AST_DIR_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 4'h1) |=> (padOe[3:0] == $past(wrData))); // R2

  AST_NO_PULL_ON_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe & padPu) == 12'h000)); // R3

  AST_SER_IN_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    mode.serEn |-> (!padOe[4] && serIn == padIn[4])); // R5

  AST_SER_OUT_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    mode.serEn |-> (padOe[5] && padOut[5] == serOut)); // R5

  AST_MASTER_CLK_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (mode.serEn && !mode.serSlave) |-> (padOe[6] && padOut[6] == serClkOut)); // R6

  AST_SLAVE_CLK_IN: assert property (@(posedge clk) disable iff (!rstN)
    (mode.serEn && mode.serSlave) |-> (!padOe[6] && serClkIn == padIn[6])); // R7

  AST_LCD_CLK_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    mode.lcdClkEn |-> (padOe[10] && padOut[10] == lcdClk)); // R9
endmodule

bind gpio_port gpio_port_checker i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .addr      (addr),
  .wrData    (wrData),
  .padIn     (padIn),
  .padOut    (padOut),
  .padOe     (padOe),
  .padPu     (padPu),
  .serOut    (serOut),
  .serClkOut (serClkOut),
  .serIn     (serIn),
  .serClkIn  (serClkIn),
  .lcdClk    (lcdClk),
  .mode      (mode)
);

// File: tb/test_gpio_port.sv
module test_gpio_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [3:0]  wrData = '0;
  logic [3:0]  rdData;
  logic [11:0] padIn = '0;
  logic [11:0] padOut, padOe, padPu;
  logic        serOut = 1'b0, serClkOut = 1'b0, serRdyOut = 1'b0;
  logic        serIn, serClkIn;
  logic        lcdClk = 1'b0, lcdFrame = 1'b0;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .padPu(padPu), .serOut(serOut), .serClkOut(serClkOut),
    .serRdyOut(serRdyOut), .serIn(serIn), .serClkIn(serClkIn),
    .lcdClk(lcdClk), .lcdFrame(lcdFrame)
  );

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [3:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic t_reset();
    logic [3:0] v;
    for (int g = 0; g < 3; g++) begin
      busRead(4'(g*4+1), v); check("R1 dir reset", {8'h0, v}, 12'h000);
      busRead(4'(g*4+2), v); check("R1 pull reset", {8'h0, v}, 12'h00F);
    end
    busRead(4'hC, v); check("R1 mode reset", {8'h0, v}, 12'h000);
    check("R1 oe reset", padOe, 12'h000);
    check("R1 pu reset", padPu, 12'hFFF);
    check("R1 ser idle", {10'h0, serIn, serClkIn}, 12'h003);
  endtask

  task automatic t_output();
    busWrite(4'h1, 4'b0101);
    busWrite(4'h0, 4'b0011);
    check("R2 oe", {8'h0, padOe[3:0]}, 12'h005);
    check("R2 out", {8'h0, padOut[3:0] & 4'b0101}, 12'h001);
    check("R3 pu on inputs only", {8'h0, padPu[3:0]}, 12'h00A);
  endtask

  task automatic t_read();
    logic [3:0] v;
    padIn = 12'h00C;
    busRead(4'h0, v); check("R4 mixed read", {8'h0, v}, 12'h009);
    padIn = 12'h000;
    busRead(4'h0, v); check("R4 pad low read", {8'h0, v}, 12'h001);
  endtask

  task automatic t_pull();
    busWrite(4'h2, 4'b0110);
    check("R3 pull bits", {8'h0, padPu[3:0]}, 12'h002);
  endtask

  task automatic t_master();
    logic [3:0] v;
    serOut = 1'b1; serClkOut = 1'b1;
    busWrite(4'hC, 4'b0001);
    check("R5 R6 oe master", {8'h0, padOe[7:4]}, 12'h006);
    check("R5 R6 pu master", {8'h0, padPu[7:4]}, 12'h009);
    check("R5 R6 out master", {10'h0, padOut[6:5]}, 12'h003);
    padIn[4] = 1'b1; #1;
    check("R5 serIn high", {11'h0, serIn}, 12'h001);
    padIn[4] = 1'b0; serOut = 1'b0; #1;
    check("R5 serIn low", {11'h0, serIn}, 12'h000);
    check("R5 serOut follows", {11'h0, padOut[5]}, 12'h000);
    check("R6 clk in idle in master", {11'h0, serClkIn}, 12'h001);
    busWrite(4'h6, 4'b0000);
    check("R5 R6 pull cleared", {8'h0, padPu[7:4]}, 12'h000);
    busRead(4'h6, v); check("R6 pull storage read", {8'h0, v}, 12'h000);
    busWrite(4'h5, 4'b1000);
    busWrite(4'h4, 4'b1000);
    check("R8 pin7 gp oe", {11'h0, padOe[7]}, 12'h001);
    check("R8 pin7 gp out", {11'h0, padOut[7]}, 12'h001);
  endtask

  task automatic t_slave();
    logic [3:0] v;
    serRdyOut = 1'b0;
    busWrite(4'hC, 4'b0011);
    check("R7 oe slave", {8'h0, padOe[7:4]}, 12'h00A);
    check("R7 ready drive", {11'h0, padOut[7]}, 12'h000);
    busWrite(4'h6, 4'b1111);
    check("R7 pu slave", {8'h0, padPu[7:4]}, 12'h005);
    padIn[6] = 1'b1; #1;
    check("R7 clk in high", {11'h0, serClkIn}, 12'h001);
    padIn[6] = 1'b0; #1;
    check("R7 clk in low", {11'h0, serClkIn}, 12'h000);
    busWrite(4'h6, 4'b1011);
    check("R7 clk pull off", {8'h0, padPu[7:4]}, 12'h001);
    busRead(4'h5, v); check("R7 dir storage read", {8'h0, v}, 12'h008);
    serRdyOut = 1'b1; #1;
    check("R7 ready high", {11'h0, padOut[7]}, 12'h001);
  endtask

  task automatic t_takenRead();
    logic [3:0] v;
    busWrite(4'h4, 4'b1010);
    padIn[7:4] = 4'b0101;
    busRead(4'h4, v); check("R10 taken read", {8'h0, v}, 12'h00A);
  endtask

  task automatic t_serialOff();
    logic [3:0] v;
    busWrite(4'hC, 4'b0000);
    check("R5 off oe", {8'h0, padOe[7:4]}, 12'h008);
    check("R5 off out7", {11'h0, padOut[7]}, 12'h001);
    check("R5 off pu", {8'h0, padPu[7:4]}, 12'h003);
    padIn[7:4] = 4'b0000; #1;
    check("R5 off serIn idle", {11'h0, serIn}, 12'h001);
    busRead(4'h4, v); check("R4 group1 read", {8'h0, v}, 12'h008);
  endtask

  task automatic t_lcd();
    lcdClk = 1'b1; lcdFrame = 1'b0;
    busWrite(4'hC, 4'b1100);
    check("R9 oe", {8'h0, padOe[11:8]}, 12'h00C);
    check("R9 out", {10'h0, padOut[11:10]}, 12'h001);
    check("R9 pu", {8'h0, padPu[11:8]}, 12'h003);
    lcdClk = 1'b0; lcdFrame = 1'b1; #1;
    check("R9 out swap", {10'h0, padOut[11:10]}, 12'h002);
    busWrite(4'hC, 4'b0100);
    check("R9 frame released oe", {8'h0, padOe[11:8]}, 12'h004);
    check("R9 frame released pu", {8'h0, padPu[11:8]}, 12'h00B);
    check("R2 group0 untouched", {8'h0, padOe[3:0]}, 12'h005);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_output();
    t_read();
    t_pull();
    t_master();
    t_slave();
    t_takenRead();
    t_serialOff();
    t_lcd();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule